// File: doc/BRIEF.md
# Cause-Code Exception Vector Generator

This block turns an exception cause code into the address of its handler by arithmetic alone. No vector is fetched from memory, so the redirect target is ready one clock after the commit logic raises its exception-taken strobe. The branch table is a run of equally spaced entry points. Each entry is 8 bytes long and starts at a base address that software can move.

Each of the cause codes 0 to 15 has its own entry point. Every larger code goes to one shared entry point, placed just after the sixteen direct ones. In that case the block raises an alternate flag, so that the dispatcher software reads the raw code and does the decoding itself. After reset the base points at the final 256 bytes of the address space. A software write moves the base, and the write is forced onto a 256-byte boundary. Saving return state, changing privilege and flushing the pipeline are handled elsewhere.

Top module: `exc_vector_gen`

## Requirements
- R1: While reset is asserted and after its release, `vec_valid`, `vec_alt` and `vec_target` read zero until the first strobe.
- R2: A strobe with a cause code from 0 to 15 yields `vec_target` = base + cause × 8 and `vec_alt` = 0.
- R3: A strobe with any cause code above 15 yields `vec_target` = base + 128, which is the entry point after the sixteen direct ones, and `vec_alt` = 1.
- R4: `vec_valid` is high in exactly the cycle after each cycle in which `exc_take` is high, and low otherwise. Strobes on consecutive cycles give valid on consecutive cycles, each carrying its own result.
- R5: Reset sets the base to all ones above bit 7 and zeros in bits 7:0, which is 0xFFFFFF00 for a 32-bit address.
- R6: A base write stores `base_wr_data` with bits 7:0 forced to zero. The bits written there have no effect on any target.
- R7: A strobe in the same cycle as a base write uses the old base. Strobes in later cycles use the new base.
- R8: In cycles with no strobe, `vec_target` and `vec_alt` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Software write strobe for the table base |
| base_wr_data | input | ADDR_W | New table base; bits 7:0 are discarded |
| exc_take | input | 1 | Exception taken this cycle |
| exc_cause | input | CAUSE_W | Cause code qualified by `exc_take` |
| vec_valid | output | 1 | One-cycle pulse marking a new target |
| vec_target | output | ADDR_W | Handler jump address |
| vec_alt | output | 1 | Target is the shared alternate-cause entry |

## Verification
The assertions assume that `exc_cause` is stable and meaningful only when `exc_take` is high. They also assume that the base is never written to a value so high that adding the largest offset of 128 would carry out of the address width, which any 256-byte-aligned base satisfies. The stimulus changes inputs only on falling clock edges and pairs each cause code with a strobe. It uses only bases whose low byte is cleared by the block itself, so every target stays inside its 256-byte table.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int DIRECT_BITS  = 4;
  localparam int DIRECT_SLOTS = 1 << DIRECT_BITS;
  localparam int SLOT_W       = DIRECT_BITS + 1;
  localparam logic [SLOT_W-1:0] ALT_SLOT = SLOT_W'(DIRECT_SLOTS);

  typedef struct packed {
    logic              alt;
    logic [SLOT_W-1:0] slot;
  } slot_sel_t;
endpackage

// File: rtl/vec_base_reg.sv
module vec_base_reg #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q
);
  localparam logic [ADDR_W-1:0] RESET_BASE =
    {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n)     base_q <= RESET_BASE;
    else if (wr_en) base_q <= {wr_data[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  end

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[ALIGN_BITS-1:0] == '0); // R6
  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q)); // R7
endmodule

// File: rtl/vec_slot_map.sv
module vec_slot_map
  import exc_vec_pkg::*;
#(
  parameter int CAUSE_W = 8
) (
  input  logic [CAUSE_W-1:0] cause,
  output slot_sel_t          sel
);
  logic over;

  generate
    if (CAUSE_W > DIRECT_BITS) begin : g_wide
      assign over = |cause[CAUSE_W-1:DIRECT_BITS];
    end else begin : g_narrow
      assign over = 1'b0;
    end
  endgenerate

  always_comb begin
    sel.alt  = over;
    sel.slot = over ? ALT_SLOT : {1'b0, cause[DIRECT_BITS-1:0]};
  end

  always_comb begin
    AST_ALT_SLOT_TOP: assert (!sel.alt || sel.slot == ALT_SLOT); // R3
  end
endmodule

// File: rtl/vec_target_out.sv
module vec_target_out
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int STRIDE_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] base,
  input  slot_sel_t         sel,
  output logic              valid,
  output logic [ADDR_W-1:0] target,
  output logic              alt
);
  localparam int PAD_W = ADDR_W - SLOT_W - STRIDE_SHIFT;

  logic [ADDR_W-1:0] offset;
  assign offset = {{PAD_W{1'b0}}, sel.slot, {STRIDE_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      target <= '0;
      alt    <= 1'b0;
    end else begin
      valid <= take;
      if (take) begin
        target <= base + offset;
        alt    <= sel.alt;
      end
    end
  end

  AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> valid); // R4
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !valid); // R4
  AST_TARGET_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> target[STRIDE_SHIFT-1:0] == '0); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(target) && $stable(alt))); // R8
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CAUSE_W      = 8,
  parameter int ALIGN_BITS   = 8,
  parameter int STRIDE_SHIFT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_wr_en,
  input  logic [ADDR_W-1:0]  base_wr_data,
  input  logic               exc_take,
  input  logic [CAUSE_W-1:0] exc_cause,
  output logic               vec_valid,
  output logic [ADDR_W-1:0]  vec_target,
  output logic               vec_alt
);
  logic [ADDR_W-1:0] base_q;
  slot_sel_t         sel;

  vec_base_reg #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_wr_en),
    .wr_data(base_wr_data), .base_q(base_q)
  );

  vec_slot_map #(.CAUSE_W(CAUSE_W)) u_map (
    .cause(exc_cause), .sel(sel)
  );

  vec_target_out #(.ADDR_W(ADDR_W), .STRIDE_SHIFT(STRIDE_SHIFT)) u_out (
    .clk(clk), .rst_n(rst_n), .take(exc_take), .base(base_q), .sel(sel),
    .valid(vec_valid), .target(vec_target), .alt(vec_alt)
  );

  AST_ALT_IFF_HIGH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> vec_alt == ($past(exc_cause) > CAUSE_W'(DIRECT_SLOTS - 1))); // R3
  AST_TARGET_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !base_wr_en) |=> vec_target[ADDR_W-1:ALIGN_BITS] == base_q[ADDR_W-1:ALIGN_BITS]); // R2
endmodule

// File: tb/exc_vector_gen_test.sv
module exc_vector_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        exc_take = 1'b0;
  logic [7:0]  exc_cause = '0;
  logic        vec_valid;
  logic [31:0] vec_target;
  logic        vec_alt;

  int runs = 0;
  int fails = 0;
  logic [31:0] model_base;

  always #4 clk = ~clk;

  exc_vector_gen uut (
    .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .exc_take(exc_take), .exc_cause(exc_cause),
    .vec_valid(vec_valid), .vec_target(vec_target), .vec_alt(vec_alt)
  );

  localparam int NV = 10;
  localparam logic [7:0] CAUSES [NV] = '{8'd0, 8'd1, 8'd5, 8'd7, 8'd9, 8'd15, 8'd16, 8'd17, 8'd128, 8'd255};
  localparam logic [7:0] OFFS   [NV] = '{8'd0, 8'd8, 8'd40, 8'd56, 8'd72, 8'd120, 8'd128, 8'd128, 8'd128, 8'd128};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [7:0] c);
    @(negedge clk);
    exc_take  = 1'b1;
    exc_cause = c;
    @(negedge clk);
    exc_take  = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", runs + 1, fails);
    $finish;
  end

  initial begin
    model_base = 32'hFFFF_FF00;
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check("R1 valid", {31'b0, vec_valid}, 32'd0);
    check("R1 target", vec_target, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 alt after release", {31'b0, vec_alt}, 32'd0);
    check("R1 target after release", vec_target, 32'd0);

    // R2/R3/R5: table walk on reset base
    for (int i = 0; i < NV; i++) begin
      fire(CAUSES[i]);
      check(OFFS[i] == 8'd128 ? "R3 target" : "R2 target", vec_target, model_base + 32'(OFFS[i]));
      check(OFFS[i] == 8'd128 ? "R3 alt" : "R2 alt", {31'b0, vec_alt}, {31'b0, OFFS[i] == 8'd128});
      check("R4 valid pulse", {31'b0, vec_valid}, 32'd1);
      @(negedge clk);
      check("R4 valid drops", {31'b0, vec_valid}, 32'd0);
      check("R8 target holds", vec_target, model_base + 32'(OFFS[i]));
    end
    check("R5 default base", vec_target, 32'hFFFF_FF80);

    // R6: unaligned write, low byte discarded
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = 32'h1234_56AB;
    @(negedge clk);
    base_wr_en = 1'b0;
    model_base = 32'h1234_5600;
    fire(8'd3);
    check("R6 masked base", vec_target, 32'h1234_5618);
    fire(8'd200);
    check("R6 masked base alt", vec_target, 32'h1234_5680);

    // R7: write coincides with strobe
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = 32'h0000_A0FF;
    exc_take = 1'b1; exc_cause = 8'd2;
    @(negedge clk);
    base_wr_en = 1'b0; exc_take = 1'b0;
    check("R7 old base used", vec_target, 32'h1234_5610);
    model_base = 32'h0000_A000;
    fire(8'd2);
    check("R7 new base later", vec_target, 32'h0000_A010);

    // R4: back-to-back strobes
    @(negedge clk);
    exc_take = 1'b1; exc_cause = 8'd4;
    @(negedge clk);
    exc_cause = 8'd40;
    check("R4 first of pair", vec_target, 32'h0000_A020);
    check("R4 first valid", {31'b0, vec_valid}, 32'd1);
    @(negedge clk);
    exc_take = 1'b0;
    check("R4 second of pair", vec_target, 32'h0000_A080);
    check("R4 second alt", {31'b0, vec_alt}, 32'd1);
    check("R4 second valid", {31'b0, vec_valid}, 32'd1);
    @(negedge clk);
    check("R4 pair ends", {31'b0, vec_valid}, 32'd0);

    // R8: cause changes without strobe have no effect
    exc_cause = 8'd1;
    @(negedge clk);
    exc_cause = 8'd9;
    @(negedge clk);
    check("R8 no strobe target", vec_target, 32'h0000_A080);
    check("R8 no strobe alt", {31'b0, vec_alt}, 32'd1);

    // R5: reset restores default base
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_base = 32'hFFFF_FF00;
    fire(8'd15);
    check("R5 base after re-reset", vec_target, 32'hFFFF_FF78);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule